// File: doc/BRIEF.md
# Opcode-Driven Microcoded Control Unit

This block produces every datapath control signal for a small 4-bit load/store processor with 16-bit instructions. The 4-bit opcode, which is the top field of the instruction, indexes a sixteen-row control-word store. Each row is one packed control word. The row is read into a register on the rising clock edge, so the decoded controls appear one cycle after the opcode is presented. The branch decision is the only combinational path. It joins the registered branch flags with the ALU zero flag of the current cycle.

The opcode numbering is fixed. The numbers are not ordered by instruction class:

| Code | Instruction | Code | Instruction |
|------|-------------|------|-------------|
| 0 | or | 8 | lw |
| 1 | add | 9 | and |
| 2 | sub | 10 | srl |
| 3 | bneq | 11 | addi |
| 4 | beq | 12 | ori |
| 5 | sw | 13 | nor |
| 6 | j | 14 | andi |
| 7 | subi | 15 | sll |

Register-to-register operations write the register named in the lowest 4-bit field. Immediate operations, shifts and loads write the register named in bits [7:4]. Immediate operations, loads and stores take the lowest field as their second ALU operand, and shifts take it as the shift amount.

Top module: `ucode_ctl`

## Requirements
- R1: While `rst_n` is low, every output is 0. After `rst_n` rises, the outputs stay 0 until the first rising edge on which the opcode is captured.
- R2: The control outputs reflect the opcode sampled at the previous rising edge. A change of `opcode_i` between edges leaves them unchanged.
- R3: The opcode numbering is the one given in the table above.
- R4: `alu_op_o` uses these codes: ADD=0, SUB=1, AND=2, OR=3, NOR=4, SLL=5, SRL=6.
- R5: add, sub, and, or and nor assert `reg_wr_o` and `dst_low_o`. They clear `alu_src_imm_o` and all memory, branch and jump outputs, and use their own ALU code.
- R6: addi, subi, andi and ori assert `reg_wr_o` and `alu_src_imm_o`. They clear `dst_low_o` and all memory, branch and jump outputs, and use ADD, SUB, AND and OR respectively.
- R7: sll and srl assert `reg_wr_o` and `alu_src_imm_o` (the shift amount), clear `dst_low_o`, and use SLL or SRL.
- R8: lw asserts `reg_wr_o`, `alu_src_imm_o`, `mem_rd_o` and `wb_mem_o`, with ALU code ADD and `dst_low_o` clear.
- R9: sw asserts `mem_wr_o` and `alu_src_imm_o` with ALU code ADD. It clears `reg_wr_o`, `mem_rd_o` and `wb_mem_o`.
- R10: beq asserts `br_eq_o` and bneq asserts `br_ne_o`. Both use ALU code SUB on two register operands and assert no write enable.
- R11: `take_branch_o` is 1 exactly when `br_eq_o` is 1 and `alu_zero_i` is 1, or when `br_ne_o` is 1 and `alu_zero_i` is 0. It follows `alu_zero_i` within the same cycle.
- R12: j asserts only `jump_o`. All other control outputs are 0 and the ALU code is ADD.
- R13: In any cycle, at most one of `br_eq_o`, `br_ne_o` and `jump_o` is set. At most one of `mem_rd_o` and `mem_wr_o` is set. `wb_mem_o` is never set without `mem_rd_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 4 | Opcode field of the current instruction |
| alu_zero_i | input | 1 | ALU result-is-zero flag |
| reg_wr_o | output | 1 | Register file write enable |
| alu_src_imm_o | output | 1 | Second ALU operand is the low instruction field |
| alu_op_o | output | 3 | ALU operation code |
| mem_rd_o | output | 1 | Data memory read enable |
| mem_wr_o | output | 1 | Data memory write enable |
| wb_mem_o | output | 1 | Write-back value comes from memory |
| dst_low_o | output | 1 | Destination is the low field (set) or bits [7:4] (clear) |
| br_eq_o | output | 1 | Instruction is branch-if-equal |
| br_ne_o | output | 1 | Instruction is branch-if-not-equal |
| jump_o | output | 1 | Instruction is an unconditional jump |
| take_branch_o | output | 1 | Conditional branch is taken |

## Verification
The assertions check the structural invariants on every cycle:
- mutual exclusion of the flow-control flags and of the memory enables;
- no write enable on a branch, store or jump;
- the load-implies-write-back pairing;
- the branch-taken equation against the zero flag;
- the one-cycle capture of a store or jump opcode.

Only the bench's scenarios can show that every one of the sixteen rows carries the exact field values for its instruction. They also show the reset state, the hold of the outputs while the opcode changes between edges, and the resumption of decoding after a reset in the middle of a run.

// File: rtl/ucode_ctl_pkg.sv
package ucode_ctl_pkg;

  localparam int OPC_W   = 4;
  localparam int ALUOP_W = 3;

  typedef enum logic [OPC_W-1:0] {
    OPC_OR   = 4'd0,
    OPC_ADD  = 4'd1,
    OPC_SUB  = 4'd2,
    OPC_BNE  = 4'd3,
    OPC_BEQ  = 4'd4,
    OPC_SW   = 4'd5,
    OPC_J    = 4'd6,
    OPC_SUBI = 4'd7,
    OPC_LW   = 4'd8,
    OPC_AND  = 4'd9,
    OPC_SRL  = 4'd10,
    OPC_ADDI = 4'd11,
    OPC_ORI  = 4'd12,
    OPC_NOR  = 4'd13,
    OPC_ANDI = 4'd14,
    OPC_SLL  = 4'd15
  } opcode_e;

  typedef enum logic [ALUOP_W-1:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_NOR = 3'd4,
    ALU_SLL = 3'd5,
    ALU_SRL = 3'd6
  } alu_op_e;

  typedef struct packed {
    logic    reg_wr;
    logic    src_imm;
    alu_op_e alu_op;
    logic    mem_rd;
    logic    mem_wr;
    logic    wb_mem;
    logic    dst_low;
    logic    br_eq;
    logic    br_ne;
    logic    jump;
  } ctl_word_t;

  localparam int CW_W = $bits(ctl_word_t);

  localparam ctl_word_t CW_IDLE = '{
    reg_wr: 1'b0, src_imm: 1'b0, alu_op: ALU_ADD, mem_rd: 1'b0,
    mem_wr: 1'b0, wb_mem: 1'b0, dst_low: 1'b0, br_eq: 1'b0,
    br_ne: 1'b0, jump: 1'b0
  };

  // Register-to-register arithmetic or logic row
  function automatic ctl_word_t cw_reg_op(input alu_op_e op);
    ctl_word_t w;
    w         = CW_IDLE;
    w.reg_wr  = 1'b1;
    w.dst_low = 1'b1;
    w.alu_op  = op;
    return w;
  endfunction

  // Immediate or shift-amount row: writes the register in bits [7:4]
  function automatic ctl_word_t cw_imm_op(input alu_op_e op);
    ctl_word_t w;
    w         = CW_IDLE;
    w.reg_wr  = 1'b1;
    w.src_imm = 1'b1;
    w.alu_op  = op;
    return w;
  endfunction

  // Builds the microcode row for one opcode (R3..R12)
  function automatic ctl_word_t build_row(input logic [OPC_W-1:0] code);
    ctl_word_t w;
    w = CW_IDLE;
    case (opcode_e'(code))
      OPC_ADD:  w = cw_reg_op(ALU_ADD);
      OPC_SUB:  w = cw_reg_op(ALU_SUB);
      OPC_AND:  w = cw_reg_op(ALU_AND);
      OPC_OR:   w = cw_reg_op(ALU_OR);
      OPC_NOR:  w = cw_reg_op(ALU_NOR);
      OPC_ADDI: w = cw_imm_op(ALU_ADD);
      OPC_SUBI: w = cw_imm_op(ALU_SUB);
      OPC_ANDI: w = cw_imm_op(ALU_AND);
      OPC_ORI:  w = cw_imm_op(ALU_OR);
      OPC_SLL:  w = cw_imm_op(ALU_SLL);
      OPC_SRL:  w = cw_imm_op(ALU_SRL);
      OPC_LW: begin
        w        = cw_imm_op(ALU_ADD);
        w.mem_rd = 1'b1;
        w.wb_mem = 1'b1;
      end
      OPC_SW: begin
        w.src_imm = 1'b1;
        w.mem_wr  = 1'b1;
      end
      OPC_BEQ: begin
        w.alu_op = ALU_SUB;
        w.br_eq  = 1'b1;
      end
      OPC_BNE: begin
        w.alu_op = ALU_SUB;
        w.br_ne  = 1'b1;
      end
      OPC_J:    w.jump = 1'b1;
      default:  w = CW_IDLE;
    endcase
    return w;
  endfunction

  // Branch resolution (R11)
  function automatic logic branch_taken(input logic eq, input logic ne,
                                        input logic zero);
    return (eq & zero) | (ne & ~zero);
  endfunction

endpackage

// File: rtl/ucode_rom.sv
module ucode_rom
  import ucode_ctl_pkg::*;
#(
  parameter int ADDR_W = OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  output ctl_word_t         word_o
);

  localparam int DEPTH = 1 << ADDR_W;

  ctl_word_t rows [DEPTH];

  // Every row is computed from the opcode it answers; codes wider than the
  // opcode field fall back to the idle word, which has no write enables.
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_row
    if (gi < (1 << OPC_W)) begin : g_used
      assign rows[gi] = build_row(OPC_W'(gi));
    end else begin : g_spare
      assign rows[gi] = CW_IDLE;
    end
  end

  // Registered read: one cycle from opcode to control word (R2)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_o <= CW_IDLE;
    else        word_o <= rows[addr_i];
  end

endmodule

// File: rtl/branch_resolve.sv
module branch_resolve
  import ucode_ctl_pkg::*;
(
  input  logic br_eq_i,
  input  logic br_ne_i,
  input  logic zero_i,
  output logic take_o
);

  always_comb take_o = branch_taken(br_eq_i, br_ne_i, zero_i);

endmodule

// File: rtl/ucode_ctl.sv
module ucode_ctl
  import ucode_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] opcode_i,
  input  logic       alu_zero_i,
  output logic       reg_wr_o,
  output logic       alu_src_imm_o,
  output logic [2:0] alu_op_o,
  output logic       mem_rd_o,
  output logic       mem_wr_o,
  output logic       wb_mem_o,
  output logic       dst_low_o,
  output logic       br_eq_o,
  output logic       br_ne_o,
  output logic       jump_o,
  output logic       take_branch_o
);

  ctl_word_t cw_q;

  ucode_rom #(.ADDR_W(OPC_W)) u_rom (
    .clk    (clk),
    .rst_n  (rst_n),
    .addr_i (opcode_i),
    .word_o (cw_q)
  );

  assign reg_wr_o      = cw_q.reg_wr;
  assign alu_src_imm_o = cw_q.src_imm;
  assign alu_op_o      = cw_q.alu_op;
  assign mem_rd_o      = cw_q.mem_rd;
  assign mem_wr_o      = cw_q.mem_wr;
  assign wb_mem_o      = cw_q.wb_mem;
  assign dst_low_o     = cw_q.dst_low;
  assign br_eq_o       = cw_q.br_eq;
  assign br_ne_o       = cw_q.br_ne;
  assign jump_o        = cw_q.jump;

  branch_resolve u_br (
    .br_eq_i (cw_q.br_eq),
    .br_ne_i (cw_q.br_ne),
    .zero_i  (alu_zero_i),
    .take_o  (take_branch_o)
  );

endmodule

// File: rtl/ucode_ctl_chk.sv
module ucode_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] opcode_i,
  input logic       alu_zero_i,
  input logic       reg_wr_o,
  input logic       alu_src_imm_o,
  input logic       mem_rd_o,
  input logic       mem_wr_o,
  input logic       wb_mem_o,
  input logic       br_eq_o,
  input logic       br_ne_o,
  input logic       jump_o,
  input logic       take_branch_o
);

  // R13: flow-control flags exclusive
  a_r13_flow_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({br_eq_o, br_ne_o, jump_o}));

  // R13: memory enables exclusive, write-back from memory only on a read
  a_r13_mem_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o) && (!wb_mem_o || mem_rd_o));

  // R11: branch decision against zero flag
  a_r11_take_branch: assert property (@(posedge clk) disable iff (!rst_n)
    take_branch_o == ((br_eq_o && alu_zero_i) || (br_ne_o && !alu_zero_i)));

  // R10: branches write nothing
  a_r10_branch_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (br_eq_o || br_ne_o) |-> (!reg_wr_o && !mem_wr_o && !mem_rd_o));

  // R8: loads write the register file through the immediate path
  a_r8_load_shape: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |-> (reg_wr_o && alu_src_imm_o && wb_mem_o));

  // R9: a store never writes the register file
  a_r9_store_no_regwr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |-> (!reg_wr_o && alu_src_imm_o));

  // R2 + R9: store opcode captured at the previous edge shows as a store
  a_r2_store_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && opcode_i == 4'd5) |=> mem_wr_o);

  // R2 + R12: jump opcode captured at the previous edge shows as a jump
  a_r12_jump_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && opcode_i == 4'd6) |=> (jump_o && !reg_wr_o && !mem_wr_o));

endmodule

bind ucode_ctl ucode_ctl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .opcode_i      (opcode_i),
  .alu_zero_i    (alu_zero_i),
  .reg_wr_o      (reg_wr_o),
  .alu_src_imm_o (alu_src_imm_o),
  .mem_rd_o      (mem_rd_o),
  .mem_wr_o      (mem_wr_o),
  .wb_mem_o      (wb_mem_o),
  .br_eq_o       (br_eq_o),
  .br_ne_o       (br_ne_o),
  .jump_o        (jump_o),
  .take_branch_o (take_branch_o)
);

// File: tb/ucode_ctl_bench.sv
module ucode_ctl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] opcode_i = 4'd0;
  logic       alu_zero_i = 1'b0;
  logic       reg_wr_o, alu_src_imm_o, mem_rd_o, mem_wr_o, wb_mem_o;
  logic       dst_low_o, br_eq_o, br_ne_o, jump_o, take_branch_o;
  logic [2:0] alu_op_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  ucode_ctl u_ucode_ctl (
    .clk (clk), .rst_n (rst_n), .opcode_i (opcode_i), .alu_zero_i (alu_zero_i),
    .reg_wr_o (reg_wr_o), .alu_src_imm_o (alu_src_imm_o), .alu_op_o (alu_op_o),
    .mem_rd_o (mem_rd_o), .mem_wr_o (mem_wr_o), .wb_mem_o (wb_mem_o),
    .dst_low_o (dst_low_o), .br_eq_o (br_eq_o), .br_ne_o (br_ne_o),
    .jump_o (jump_o), .take_branch_o (take_branch_o)
  );

  // Observed word packed as {reg_wr, imm, op[2:0], mrd, mwr, wbm, dlow, beq, bne, j}
  function automatic logic [11:0] observed();
    return {reg_wr_o, alu_src_imm_o, alu_op_o, mem_rd_o, mem_wr_o, wb_mem_o,
            dst_low_o, br_eq_o, br_ne_o, jump_o};
  endfunction

  // Reference table stated directly from R3..R12
  function automatic logic [11:0] expected(input logic [3:0] opc);
    case (opc)
      4'd0:  return 12'b1_0_011_000_1_000; // or   R5
      4'd1:  return 12'b1_0_000_000_1_000; // add  R5
      4'd2:  return 12'b1_0_001_000_1_000; // sub  R5
      4'd3:  return 12'b0_0_001_000_0_010; // bneq R10
      4'd4:  return 12'b0_0_001_000_0_100; // beq  R10
      4'd5:  return 12'b0_1_000_010_0_000; // sw   R9
      4'd6:  return 12'b0_0_000_000_0_001; // j    R12
      4'd7:  return 12'b1_1_001_000_0_000; // subi R6
      4'd8:  return 12'b1_1_000_101_0_000; // lw   R8
      4'd9:  return 12'b1_0_010_000_1_000; // and  R5
      4'd10: return 12'b1_1_110_000_0_000; // srl  R7
      4'd11: return 12'b1_1_000_000_0_000; // addi R6
      4'd12: return 12'b1_1_011_000_0_000; // ori  R6
      4'd13: return 12'b1_0_100_000_1_000; // nor  R5
      4'd14: return 12'b1_1_010_000_0_000; // andi R6
      default: return 12'b1_1_101_000_0_000; // sll R7
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] opc);
    case (opc)
      4'd0, 4'd1, 4'd2, 4'd9, 4'd13: return "R5";
      4'd7, 4'd11, 4'd12, 4'd14:     return "R6";
      4'd10, 4'd15:                  return "R7";
      4'd8:                          return "R8";
      4'd5:                          return "R9";
      4'd3, 4'd4:                    return "R10";
      default:                       return "R12";
    endcase
  endfunction

  task automatic check(input string req, input logic [11:0] act,
                       input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] opc);
    @(negedge clk);
    opcode_i = opc;
    @(posedge clk);
    #1;
  endtask

  // R1: outputs clear in reset and right after release
  task automatic t_reset();
    opcode_i = 4'd8;
    alu_zero_i = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1", {observed(), take_branch_o}[11:0], 12'd0);
    check("R1", {11'd0, take_branch_o}, 12'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", observed(), 12'd0);
  endtask

  // R3..R12: every row of the store against the reference table
  task automatic t_sweep();
    for (int i = 0; i < 16; i++) begin
      issue(4'(i));
      check(req_of(4'(i)), observed(), expected(4'(i)));
    end
    // R4 and R3 spot checks through the ALU code field
    issue(4'd13);
    check("R4", {9'd0, alu_op_o}, 12'd4);
    issue(4'd15);
    check("R3", {9'd0, alu_op_o}, 12'd5);
  endtask

  // R2: opcode changes between edges leave outputs unchanged
  task automatic t_latency();
    issue(4'd5);
    @(negedge clk);
    opcode_i = 4'd8;
    #1;
    check("R2", observed(), expected(4'd5));
    opcode_i = 4'd6;
    @(posedge clk);
    #1;
    check("R2", observed(), expected(4'd6));
  endtask

  // R11: branch decision follows the zero flag combinationally
  task automatic t_branch();
    issue(4'd4);
    alu_zero_i = 1'b1; #1;
    check("R11", {11'd0, take_branch_o}, 12'd1);
    alu_zero_i = 1'b0; #1;
    check("R11", {11'd0, take_branch_o}, 12'd0);
    issue(4'd3);
    alu_zero_i = 1'b0; #1;
    check("R11", {11'd0, take_branch_o}, 12'd1);
    alu_zero_i = 1'b1; #1;
    check("R11", {11'd0, take_branch_o}, 12'd0);
    issue(4'd6);
    alu_zero_i = 1'b1; #1;
    check("R11", {11'd0, take_branch_o}, 12'd0);
    issue(4'd1);
    alu_zero_i = 1'b0; #1;
    check("R11", {11'd0, take_branch_o}, 12'd0);
  endtask

  // R1 + R13: reset mid-run clears, then decoding resumes
  task automatic t_mid_reset();
    issue(4'd8);
    check("R13", {10'd0, mem_rd_o, wb_mem_o}, 12'd3);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", observed(), 12'd0);
    @(negedge clk);
    rst_n = 1'b1;
    issue(4'd5);
    check("R13", {10'd0, mem_rd_o, mem_wr_o}, 12'd1);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_latency();
    t_branch();
    t_mid_reset();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule